// File: doc/BRIEF.md
# Decoded Integer ALU with Operation Decoder

This block pairs a combinational integer ALU with the decoder that picks its operation from the instruction word. Register-format instructions (opcode zero) take their operation from the function field. Immediate-format instructions take theirs from the opcode. Immediate-format instructions also replace operand B with the 16-bit immediate, widened to the datapath width. The widening is sign extension or zero extension, depending on the instruction.

A multicycle control sequencer drives the `force_add` input during the steps where it only needs a plain sum. These steps are the program-counter increment, the memory address and the branch target. The force overrides whatever the instruction fields hold, and operand B is used exactly as supplied.

For the two conditional branches, the ALU subtracts the register operands. The zero flag then drives a taken-branch output: taken on zero for branch-if-equal, taken on non-zero for branch-if-not-equal.

Top module: `alu_decoded`

## Requirements
- R1: With opcode 6'h00, function code 6'h20 gives A+B, 6'h22 gives A−B, 6'h24 gives A AND B, and 6'h25 gives A OR B. All arithmetic wraps modulo 2^32.
- R2: With opcode 6'h00, function code 6'h00 gives B shifted left, and 6'h02 gives B shifted right logically. The shift count is instruction bits [10:6]. Operand A has no effect on the result.
- R3: Opcodes 6'h08 (add immediate), 6'h23 (load) and 6'h2B (store) give A plus the sign-extended instruction bits [15:0]. Operand B is ignored.
- R4: Opcode 6'h0C gives A AND the zero-extended bits [15:0]. Opcode 6'h0D gives A OR the zero-extended bits [15:0].
- R5: Opcodes 6'h04 (branch if equal) and 6'h05 (branch if not equal) give A−B. `br_take` is high for 6'h04 when A equals B, and for 6'h05 when A differs from B.
- R6: While `force_add` is high, the result is A+B and `br_take` is low, whatever the instruction word holds.
- R7: `zero` is high exactly when the result is all zeros.
- R8: Any other opcode, and any other function code under opcode 6'h00, gives a result of 0.
- R9: `br_take` is low for every instruction other than the two branch opcodes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word: opcode [31:26], shift count [10:6], function [5:0], immediate [15:0] |
| force_add | input | 1 | Sequencer override that forces A+B |
| opnd_a | input | DATA_W | Operand A |
| opnd_b | input | DATA_W | Operand B (register value or sequencer-supplied value) |
| result | output | DATA_W | ALU result |
| zero | output | 1 | Result equals zero |
| br_take | output | 1 | Conditional branch is taken |

## Verification
The block holds no state, so any wrong internal decode shows at `result`, `zero` or `br_take` as soon as the inputs settle. Examples of such faults are an operation selected from the wrong field, the wrong extension, or shift operands swapped. The sweep crosses eight boundary operand values with every supported and unsupported instruction form. This exposes each mis-decode on at least one pair. Equal and unequal operand pairs drive both polarities of the branch decision.

// File: rtl/alu_dec_pkg.sv
package alu_dec_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_BNE   = 6'h05;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_SRL = 6'h02;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLL, ALU_SRL, ALU_NONE
    } alu_fn_e;

    typedef enum logic [1:0] {
        BSRC_REG, BSRC_SEXT, BSRC_ZEXT
    } bsrc_e;

    typedef enum logic [1:0] {
        BRK_NONE, BRK_EQ, BRK_NE
    } brk_e;

    typedef struct packed {
        alu_fn_e fn;
        bsrc_e   bsrc;
        brk_e    brk;
    } alu_ctl_t;

    typedef struct packed {
        logic [5:0]  opcode;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [4:0]  rd;
        logic [4:0]  shamt;
        logic [5:0]  funct;
    } instr_fields_t;

    function automatic logic [15:0] imm_of(input instr_fields_t f);
        return {f.rd, f.shamt, f.funct};
    endfunction

endpackage

// File: rtl/alu_ctl_dec.sv
module alu_ctl_dec
    import alu_dec_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic       force_add,
    output alu_ctl_t   ctl
);

    alu_fn_e r_fn;

    always_comb begin
        unique case (funct)
            FN_ADD:  r_fn = ALU_ADD;
            FN_SUB:  r_fn = ALU_SUB;
            FN_AND:  r_fn = ALU_AND;
            FN_OR:   r_fn = ALU_OR;
            FN_SLL:  r_fn = ALU_SLL;
            FN_SRL:  r_fn = ALU_SRL;
            default: r_fn = ALU_NONE;
        endcase
    end

    always_comb begin
        ctl = '{fn: ALU_NONE, bsrc: BSRC_REG, brk: BRK_NONE};
        if (force_add) begin
            ctl.fn = ALU_ADD;
        end else begin
            unique case (opcode)
                OPC_RTYPE: ctl.fn = r_fn;
                OPC_ADDI, OPC_LOAD, OPC_STORE: begin
                    ctl.fn   = ALU_ADD;
                    ctl.bsrc = BSRC_SEXT;
                end
                OPC_ANDI: begin
                    ctl.fn   = ALU_AND;
                    ctl.bsrc = BSRC_ZEXT;
                end
                OPC_ORI: begin
                    ctl.fn   = ALU_OR;
                    ctl.bsrc = BSRC_ZEXT;
                end
                OPC_BEQ: begin
                    ctl.fn  = ALU_SUB;
                    ctl.brk = BRK_EQ;
                end
                OPC_BNE: begin
                    ctl.fn  = ALU_SUB;
                    ctl.brk = BRK_NE;
                end
                default: ctl.fn = ALU_NONE;
            endcase
        end
    end

    always_comb begin
        if (ctl.brk != BRK_NONE) begin
            AST_BRANCH_IS_SUB: assert (ctl.fn == ALU_SUB && !force_add)
                else $error("branch compare not a subtract"); // R5
        end
    end

endmodule

// File: rtl/alu_imm_ext.sv
module alu_imm_ext
    import alu_dec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [15:0]       imm,
    input  bsrc_e             bsrc,
    input  logic [DATA_W-1:0] b_reg,
    output logic [DATA_W-1:0] b_eff
);

    localparam int IMM_W = 16;
    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_s;
    logic [DATA_W-1:0] imm_z;

    generate
        if (PAD_W > 0) begin : g_pad
            assign imm_s = {{PAD_W{imm[IMM_W-1]}}, imm};
            assign imm_z = {{PAD_W{1'b0}}, imm};
        end else begin : g_trunc
            assign imm_s = imm[DATA_W-1:0];
            assign imm_z = imm[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (bsrc)
            BSRC_SEXT: b_eff = imm_s;
            BSRC_ZEXT: b_eff = imm_z;
            default:   b_eff = b_reg;
        endcase
    end

    always_comb begin
        if (bsrc == BSRC_ZEXT && PAD_W > 0) begin
            AST_ZEXT_UPPER_CLEAR: assert (b_eff[DATA_W-1:IMM_W] == '0)
                else $error("zero-extended immediate has upper bits set"); // R4
        end
    end

endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_dec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_fn_e           fn,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [4:0]        shamt,
    output logic [DATA_W-1:0] y,
    output logic              zero
);

    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] sh;
    assign sh = SH_W'(shamt);

    always_comb begin
        unique case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLL: y = b << sh;
            ALU_SRL: y = b >> sh;
            default: y = '0;
        endcase
    end

    assign zero = ~|y;

    always_comb begin
        if (fn == ALU_SLL || fn == ALU_SRL) begin
            AST_SHIFT_KEEPS_BITS: assert ($countones(y) <= $countones(b))
                else $error("shift created set bits"); // R2
        end
        if (fn == ALU_SUB && a == b) begin
            AST_SUB_EQUAL_ZERO: assert (zero)
                else $error("equal operands did not zero"); // R7
        end
    end

endmodule

// File: rtl/alu_decoded.sv
module alu_decoded
    import alu_dec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [31:0]       instr,
    input  logic              force_add,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              zero,
    output logic              br_take
);

    instr_fields_t     f;
    alu_ctl_t          ctl;
    logic [DATA_W-1:0] b_eff;

    assign f = instr_fields_t'(instr);

    alu_ctl_dec u_dec (
        .opcode    (f.opcode),
        .funct     (f.funct),
        .force_add (force_add),
        .ctl       (ctl)
    );

    alu_imm_ext #(.DATA_W(DATA_W)) u_ext (
        .imm   (imm_of(f)),
        .bsrc  (ctl.bsrc),
        .b_reg (opnd_b),
        .b_eff (b_eff)
    );

    alu_core #(.DATA_W(DATA_W)) u_core (
        .fn    (ctl.fn),
        .a     (opnd_a),
        .b     (b_eff),
        .shamt (f.shamt),
        .y     (result),
        .zero  (zero)
    );

    always_comb begin
        unique case (ctl.brk)
            BRK_EQ:  br_take = zero;
            BRK_NE:  br_take = ~zero;
            default: br_take = 1'b0;
        endcase
    end

    always_comb begin
        if (force_add) begin
            AST_FORCE_ADD: assert (result == opnd_a + opnd_b && !br_take)
                else $error("override did not add"); // R6
        end
        if (br_take) begin
            AST_BR_ONLY_BRANCH: assert (f.opcode == OPC_BEQ || f.opcode == OPC_BNE)
                else $error("branch taken on non-branch"); // R9
        end
        if (br_take && f.opcode == OPC_BEQ) begin
            AST_BEQ_EQUAL: assert (opnd_a == opnd_b)
                else $error("equal-branch taken on unequal operands"); // R5
        end
    end

endmodule

// File: tb/alu_decoded_bench.sv
module alu_decoded_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = '0;
    logic        force_add = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        zero;
    logic        br_take;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    alu_decoded u_alu_decoded (
        .instr     (instr),
        .force_add (force_add),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .result    (result),
        .zero      (zero),
        .br_take   (br_take)
    );

    function automatic logic [31:0] pick(input int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h7FFF_FFFF;
            5: return 32'h1234_8765;
            6: return 32'h0000_8000;
            default: return 32'hA5A5_5A5A;
        endcase
    endfunction

    function automatic logic [31:0] model(input logic [31:0] w, input logic fa,
                                          input logic [31:0] a, input logic [31:0] b);
        logic [31:0] se;
        logic [31:0] ze;
        se = {{16{w[15]}}, w[15:0]};
        ze = {16'h0, w[15:0]};
        if (fa) return a + b;
        case (w[31:26])
            6'h00: case (w[5:0])
                6'h20: return a + b;
                6'h22: return a - b;
                6'h24: return a & b;
                6'h25: return a | b;
                6'h00: return b << w[10:6];
                6'h02: return b >> w[10:6];
                default: return 32'h0;
            endcase
            6'h08, 6'h23, 6'h2B: return a + se;
            6'h0C: return a & ze;
            6'h0D: return a | ze;
            6'h04, 6'h05: return a - b;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic model_br(input logic [31:0] w, input logic fa,
                                      input logic [31:0] a, input logic [31:0] b);
        if (fa) return 1'b0;
        if (w[31:26] == 6'h04) return a == b;
        if (w[31:26] == 6'h05) return a != b;
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [31:0] w, input logic fa,
                         input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        @(negedge clk);
        instr = w; force_add = fa; opnd_a = a; opnd_b = b;
        #1;
        er = model(w, fa, a, b);
        check(tag, result, er);
        check({tag, "/R7 zero"}, {31'h0, zero}, {31'h0, er == 32'h0});
        check({tag, "/R9 br_take"}, {31'h0, br_take}, {31'h0, model_br(w, fa, a, b)});
    endtask

    function automatic logic [31:0] rtype(input logic [5:0] fn, input logic [4:0] sh,
                                          input logic [15:0] hi);
        return {6'h00, hi[9:0], sh, fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] opc, input logic [15:0] imm,
                                          input logic [9:0] regs);
        return {opc, regs, imm};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [31:0] a;
                logic [31:0] b;
                logic [15:0] imm;
                logic [4:0]  sh;
                a   = pick(i);
                b   = pick(j);
                imm = pick((i + j) % 8)[15:0] ^ 16'(j * 16'h1111);
                sh  = 5'((i * 5 + j * 3) % 32);
                apply("R1 add", rtype(6'h20, sh, imm), 1'b0, a, b);
                apply("R1 sub", rtype(6'h22, sh, imm), 1'b0, a, b);
                apply("R1 and", rtype(6'h24, sh, imm), 1'b0, a, b);
                apply("R1 or",  rtype(6'h25, sh, imm), 1'b0, a, b);
                apply("R2 sll", rtype(6'h00, sh, imm), 1'b0, a, b);
                apply("R2 srl", rtype(6'h02, sh, imm), 1'b0, a, b);
                apply("R3 addi",  itype(6'h08, imm, 10'(i)), 1'b0, a, b);
                apply("R3 load",  itype(6'h23, imm, 10'(j)), 1'b0, a, b);
                apply("R3 store", itype(6'h2B, imm, 10'(i)), 1'b0, a, b);
                apply("R4 andi", itype(6'h0C, imm, 10'(j)), 1'b0, a, b);
                apply("R4 ori",  itype(6'h0D, imm, 10'(i)), 1'b0, a, b);
                apply("R5 beq", itype(6'h04, imm, 10'(j)), 1'b0, a, b);
                apply("R5 bne", itype(6'h05, imm, 10'(i)), 1'b0, a, b);
                apply("R5 beq equal", itype(6'h04, imm, 10'(j)), 1'b0, a, a);
                apply("R5 bne equal", itype(6'h05, imm, 10'(j)), 1'b0, b, b);
                apply("R6 force add", itype(6'(i * 8 + j), imm, 10'(i)), 1'b1, a, b);
                apply("R8 bad funct", rtype(6'h3F - 6'(j), sh, imm), 1'b0, a, b);
                apply("R8 bad opcode", itype(6'h30 + 6'(i), imm, 10'(j)), 1'b0, a, b);
            end
        end
        for (int s = 0; s < 32; s++) begin
            apply("R2 sll sweep", rtype(6'h00, 5'(s), 16'h0), 1'b0, 32'hFFFF_FFFF, 32'h8000_0001);
            apply("R2 srl sweep", rtype(6'h02, 5'(s), 16'h0), 1'b0, 32'hDEAD_BEEF, 32'h8000_0001);
        end
        apply("R6 force over beq", itype(6'h04, 16'h0, 10'h0), 1'b1, 32'h5, 32'h5);
        apply("R3 sext negative", itype(6'h08, 16'hFFFF, 10'h0), 1'b0, 32'h0, 32'h0);
        apply("R4 zext high bit", itype(6'h0D, 16'h8000, 10'h0), 1'b0, 32'h0, 32'h0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule